// File: doc/BRIEF.md
# Synchronized Channel Start and Frequency Hop Controller

This block sequences the wake-up and the frequency changes of four receive channels. Each channel holds a sleep flag, a program flag, a staged and an active 32-bit oscillator frequency, and two 16-bit delay values: one for waking and one for hopping. A single shared command word selects a set of channels and requests a start, a hop, or both. The request fires at once, or waits for a rising edge on an external sync pin. Once it fires, each selected channel counts its own delay in clock cycles and then clears its sleep flag or copies its staged frequency into the active register.

Software reaches every setting through a plain single-cycle write port. Hop loads are announced to the oscillator with a one-cycle load pulse per channel that lines up with the new active word. A channel runs only while both its sleep and its program flag are low. With a frequency delay of zero, a staged frequency write goes straight to the active register. All ports are plain control or register pins, so the block has no valid/ready handshake and applies no back-pressure. Writes are accepted on every cycle that the strobe is high.

Top module: `sync_start_hop`

## Requirements
- R1: After reset every channel sleep flag is 1, every program flag is 0, every active frequency is 0 and every load pulse is 0.
- R2: A write to address 0x10 sets the sleep flags from data bits 3:0 and the program flags from data bits 11:8 (bit index = channel). The run output of a channel is 1 only when both its sleep and program flags are 0.
- R3: Per-channel registers sit at address channel*4 + offset: offset 0 is the start delay, offset 1 is the frequency delay (both data bits 15:0), offset 2 is the staged frequency (data bits 31:0).
- R4: A write to address 0x11 with bit 8 (start) set, bit 10 (pin wait) clear and select bit ch (bits 3:0) set clears that channel's sleep flag exactly D clock edges after the write edge, where D is its start delay. D = 0 clears it on the write edge itself.
- R5: With bit 10 set, the request waits for the sync pin. The pin passes two synchronizing flops and a rise detector, so the countdown is loaded on the third rising clock edge after the pin goes high, and the action happens D edges after that edge.
- R6: One rising edge of the sync pin fires only the requests armed before it. A request armed while the pin stays high waits for the next low-to-high transition.
- R7: A write to 0x11 with bit 9 (hop) set and bit 10 clear copies the staged frequency of each selected channel into its active frequency D edges after the write edge, where D is its frequency delay. The load pulse is high for exactly the one cycle in which the new value first appears.
- R8: When a channel's frequency delay is 0, a staged-frequency write loads the active frequency at once with a load pulse. When the delay is nonzero, such a write leaves the active frequency and the load pulse unchanged.
- R9: A channel whose select bit is 0 in a command write keeps its sleep flag and active frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe, one write per high cycle |
| wr_addr | input | 5 | Register address |
| wr_data | input | 32 | Register write data |
| sync_pin | input | 1 | External sync pin, asynchronous |
| chan_sleep | output | 4 | Sleep flag per channel |
| chan_prog | output | 4 | Program flag per channel |
| chan_run | output | 4 | Channel running (sleep and program both low) |
| nco_freq | output | 128 | Active frequency words, channel n at bits 32n+31:32n |
| nco_load | output | 4 | One-cycle pulse per channel on an active frequency load |

## Verification
The assertions assume that the sync pin is the only asynchronous input and that every write lasts one cycle with stable address and data. They also assume reset is held for at least one clock edge, so that the checks on frequency stability and sleep rises compare against reset values. The stimulus drives all ports on the falling edge and keeps the pin low for at least three cycles between its pulses. It also avoids rewriting a delay or the sleep flags while a countdown on that channel is running, because the outcome of that overlap is not defined by the requirements.

// File: rtl/sh_pkg.sv
package sh_pkg;
  localparam int CMD_START_BIT = 8;
  localparam int CMD_HOP_BIT   = 9;
  localparam int CMD_PIN_BIT   = 10;
  localparam int MODE_PROG_LSB = 8;

  localparam logic [1:0] REG_START_HOLD = 2'd0;
  localparam logic [1:0] REG_FREQ_HOLD  = 2'd1;
  localparam logic [1:0] REG_FREQ_STAGE = 2'd2;

  typedef struct packed {
    logic start;
    logic hop;
    logic pin;
  } sync_cmd_t;
endpackage

// File: rtl/sh_pin_sync.sv
module sh_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_rise
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign pin_rise = sync_q & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> !pin_rise) else $error("rise pulse longer than one cycle"); // R6
endmodule

// File: rtl/sh_holdoff.sv
module sh_holdoff #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_soft,
  input  logic              arm_pin,
  input  logic              pin_rise,
  input  logic [HOLD_W-1:0] hold,
  output logic              fire
);
  localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

  logic              wait_pin;
  logic              running;
  logic [HOLD_W-1:0] cnt;
  logic              trig;

  assign trig = arm_soft | (wait_pin & pin_rise);
  assign fire = (trig && hold == '0) || (!trig && running && cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_pin <= 1'b0;
      running  <= 1'b0;
      cnt      <= '0;
    end else begin
      if (trig) begin
        wait_pin <= 1'b0;
        running  <= (hold != '0);
        cnt      <= hold;
      end else if (running) begin
        if (cnt == ONE) running <= 1'b0;
        else            cnt     <= cnt - ONE;
      end
      if (arm_pin) wait_pin <= 1'b1;
    end
  end

  AST_HOLD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> cnt != '0) else $error("running with zero count"); // R4
  AST_HOLD_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !trig && cnt > ONE) |=> (running && cnt == $past(cnt) - ONE))
    else $error("countdown skipped a step"); // R4
  AST_HOLD_END: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !trig && cnt == ONE) |=> !running) else $error("countdown overran"); // R7
  AST_PIN_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !arm_pin) |=> !wait_pin) else $error("pin arm kept after trigger"); // R6
endmodule

// File: rtl/sh_channel.sv
module sh_channel
  import sh_pkg::*;
#(
  parameter int HOLD_W = 16,
  parameter int FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic              mode_sleep,
  input  logic              mode_prog,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [FREQ_W-1:0] reg_data,
  input  logic              sync_sel,
  input  sync_cmd_t         cmd,
  input  logic              pin_rise,
  output logic              sleep,
  output logic              prog,
  output logic [FREQ_W-1:0] active_freq,
  output logic              freq_load
);
  logic [HOLD_W-1:0] start_hold, freq_hold;
  logic [FREQ_W-1:0] stage_freq;
  logic start_fire, hop_fire, stage_wr;

  assign stage_wr = reg_wr && reg_sel == REG_FREQ_STAGE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_hold <= '0;
      freq_hold  <= '0;
      stage_freq <= '0;
    end else if (reg_wr) begin
      case (reg_sel)
        REG_START_HOLD: start_hold <= reg_data[HOLD_W-1:0];
        REG_FREQ_HOLD:  freq_hold  <= reg_data[HOLD_W-1:0];
        REG_FREQ_STAGE: stage_freq <= reg_data;
        default: ;
      endcase
    end
  end

  sh_holdoff #(.HOLD_W(HOLD_W)) u_start (
    .clk(clk), .rst_n(rst_n),
    .arm_soft(sync_sel & cmd.start & ~cmd.pin),
    .arm_pin (sync_sel & cmd.start &  cmd.pin),
    .pin_rise(pin_rise), .hold(start_hold), .fire(start_fire)
  );

  sh_holdoff #(.HOLD_W(HOLD_W)) u_hop (
    .clk(clk), .rst_n(rst_n),
    .arm_soft(sync_sel & cmd.hop & ~cmd.pin),
    .arm_pin (sync_sel & cmd.hop &  cmd.pin),
    .pin_rise(pin_rise), .hold(freq_hold), .fire(hop_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep <= 1'b1;
      prog  <= 1'b0;
    end else if (mode_wr) begin
      sleep <= mode_sleep;
      prog  <= mode_prog;
    end else if (start_fire) begin
      sleep <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_freq <= '0;
      freq_load   <= 1'b0;
    end else begin
      freq_load <= 1'b0;
      if (stage_wr && freq_hold == '0) begin
        active_freq <= reg_data;
        freq_load   <= 1'b1;
      end else if (hop_fire) begin
        active_freq <= stage_freq;
        freq_load   <= 1'b1;
      end
    end
  end

  AST_SLEEP_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> $past(mode_wr)) else $error("sleep set without a write"); // R2
  AST_FREQ_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_load |-> $stable(active_freq)) else $error("frequency moved without load"); // R7
  AST_STAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_wr && freq_hold != '0 && !hop_fire) |=> !freq_load)
    else $error("staged write leaked to active"); // R8
endmodule

// File: rtl/sync_start_hop.sv
module sync_start_hop
  import sh_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int HOLD_W = 16,
  parameter int FREQ_W = 32,
  parameter int DATA_W = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     sync_pin,
  output logic [NUM_CH-1:0]        chan_sleep,
  output logic [NUM_CH-1:0]        chan_prog,
  output logic [NUM_CH-1:0]        chan_run,
  output logic [NUM_CH*FREQ_W-1:0] nco_freq,
  output logic [NUM_CH-1:0]        nco_load
);
  logic              glob;
  logic [ADDR_W-2:0] glob_idx;
  logic              mode_wr, sync_wr, pin_rise;
  sync_cmd_t         cmd;

  assign glob     = wr_addr[ADDR_W-1];
  assign glob_idx = wr_addr[ADDR_W-2:0];
  assign mode_wr  = wr_en && glob && glob_idx == (ADDR_W-1)'(0);
  assign sync_wr  = wr_en && glob && glob_idx == (ADDR_W-1)'(1);
  assign cmd.start = wr_data[CMD_START_BIT];
  assign cmd.hop   = wr_data[CMD_HOP_BIT];
  assign cmd.pin   = wr_data[CMD_PIN_BIT];

  sh_pin_sync u_pin (
    .clk(clk), .rst_n(rst_n), .pin_in(sync_pin), .pin_rise(pin_rise)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_en && !glob && wr_addr[ADDR_W-2:2] == CH_W'(ch);

    sh_channel #(.HOLD_W(HOLD_W), .FREQ_W(FREQ_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_wr    (mode_wr),
      .mode_sleep (wr_data[ch]),
      .mode_prog  (wr_data[MODE_PROG_LSB+ch]),
      .reg_wr     (ch_wr),
      .reg_sel    (wr_addr[1:0]),
      .reg_data   (wr_data[FREQ_W-1:0]),
      .sync_sel   (sync_wr & wr_data[ch]),
      .cmd        (cmd),
      .pin_rise   (pin_rise),
      .sleep      (chan_sleep[ch]),
      .prog       (chan_prog[ch]),
      .active_freq(nco_freq[ch*FREQ_W +: FREQ_W]),
      .freq_load  (nco_load[ch])
    );

    assign chan_run[ch] = ~chan_sleep[ch] & ~chan_prog[ch];
  end
endmodule

// File: tb/sync_start_hop_bench.sv
`timescale 1ns/1ps
module sync_start_hop_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        sync_pin = 1'b0;
  logic [3:0]  chan_sleep, chan_prog, chan_run, nco_load;
  logic [127:0] nco_freq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sync_start_hop u_sync_start_hop (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_pin(sync_pin), .chan_sleep(chan_sleep),
    .chan_prog(chan_prog), .chan_run(chan_run), .nco_freq(nco_freq),
    .nco_load(nco_load)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] freq_of(input int ch);
    return nco_freq[ch*32 +: 32];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int hv[6] = '{0, 1, 2, 3, 7, 20};
    int n;
    logic [31:0] f, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(chan_sleep == 4'hF, "R1 sleep", chan_sleep, 4'hF);
    check(chan_prog == 4'h0, "R1 prog", chan_prog, 0);
    check(nco_freq == '0, "R1 freq", nco_freq[31:0], 0);
    check(nco_load == 4'h0, "R1 load", nco_load, 0);

    // R2 mode register and run combination
    wr(5'h10, 32'h0000_0100);
    check(chan_sleep == 4'h0 && chan_prog == 4'h1, "R2 mode", {chan_prog, chan_sleep}, 8'h10);
    check(chan_run == 4'hE, "R2 run", chan_run, 4'hE);
    wr(5'h10, 32'h0000_0000);
    check(chan_run == 4'hF, "R2 run all", chan_run, 4'hF);

    // R4 R3 R9 soft start sweep
    for (int ch = 0; ch < 4; ch++) begin
      for (int i = 0; i < 6; i++) begin
        wr(5'h10, 32'hF);
        wr(5'(ch*4 + 0), 32'(hv[i]));
        wr(5'h11, 32'h100 | (32'd1 << ch));
        n = 0;
        while (chan_sleep[ch] && n < 100) begin @(negedge clk); n++; end
        check(n == hv[i], "R4 start delay", n, hv[i]);
        check((chan_sleep | (4'd1 << ch)) == 4'hF, "R9 unselected asleep", chan_sleep, 4'hF);
      end
    end

    // R5 pin start
    for (int ch = 0; ch < 4; ch++) begin
      for (int i = 0; i < 4; i++) begin
        wr(5'h10, 32'hF);
        wr(5'(ch*4 + 0), 32'(hv[i]));
        wr(5'h11, 32'h500 | (32'd1 << ch));
        repeat (5) @(negedge clk);
        check(chan_sleep == 4'hF, "R5 waits for pin", chan_sleep, 4'hF);
        sync_pin = 1'b1;
        n = 0;
        while (chan_sleep[ch] && n < 100) begin @(negedge clk); n++; end
        check(n == hv[i] + 3, "R5 pin start delay", n, hv[i] + 3);
        sync_pin = 1'b0;
        repeat (4) @(negedge clk);
      end
    end

    // R7 R8 soft hop sweep
    for (int ch = 0; ch < 4; ch++) begin
      for (int i = 0; i < 6; i++) begin
        f = 32'hA500_0000 + 32'(ch * 256 + i);
        prev = freq_of(ch);
        wr(5'(ch*4 + 1), 32'd1);
        wr(5'(ch*4 + 2), f);
        check(nco_load == 4'h0 && freq_of(ch) == prev, "R8 staged held", freq_of(ch), prev);
        wr(5'(ch*4 + 1), 32'(hv[i]));
        wr(5'h11, 32'h200 | (32'd1 << ch));
        n = 0;
        while (!nco_load[ch] && n < 100) begin @(negedge clk); n++; end
        check(n == hv[i], "R7 hop delay", n, hv[i]);
        check(freq_of(ch) == f, "R7 hop value", freq_of(ch), f);
        @(negedge clk);
        check(nco_load == 4'h0, "R7 one-cycle pulse", nco_load, 0);
      end
    end

    // R8 immediate load when frequency delay is zero
    for (int ch = 0; ch < 4; ch++) begin
      f = 32'h5A00_0000 + 32'(ch);
      wr(5'(ch*4 + 1), 32'd0);
      wr(5'(ch*4 + 2), f);
      check(nco_load == (4'd1 << ch) && freq_of(ch) == f, "R8 immediate", freq_of(ch), f);
    end

    // R9 hop on channel 0 leaves channel 1 untouched
    prev = freq_of(1);
    wr(5'h01, 32'd1);
    wr(5'h02, 32'h1111_1111);
    wr(5'h11, 32'h201);
    @(negedge clk);
    check(freq_of(1) == prev && freq_of(0) == 32'h1111_1111, "R9 hop select", freq_of(1), prev);

    // R5 R6 pin hop with single trigger per rising edge
    wr(5'h02, 32'h2222_2222);
    wr(5'h01, 32'd4);
    wr(5'h11, 32'h601);
    sync_pin = 1'b1;
    n = 0;
    while (!nco_load[0] && n < 100) begin @(negedge clk); n++; end
    check(n == 7, "R5 pin hop delay", n, 7);
    check(freq_of(0) == 32'h2222_2222, "R5 pin hop value", freq_of(0), 32'h2222_2222);
    wr(5'h02, 32'h3333_3333);
    wr(5'h11, 32'h601);
    n = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (nco_load[0]) n++; end
    check(n == 0 && freq_of(0) == 32'h2222_2222, "R6 held pin no retrigger", freq_of(0), 32'h2222_2222);
    sync_pin = 1'b0;
    repeat (4) @(negedge clk);
    sync_pin = 1'b1;
    n = 0;
    while (!nco_load[0] && n < 100) begin @(negedge clk); n++; end
    check(n == 7 && freq_of(0) == 32'h3333_3333, "R6 next edge fires", freq_of(0), 32'h3333_3333);
    sync_pin = 1'b0;
    repeat (4) @(negedge clk);
    n = 0;
    sync_pin = 1'b1;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (nco_load[0]) n++; end
    check(n == 0, "R6 disarmed after fire", n, 0);
    sync_pin = 1'b0;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule